// File: doc/BRIEF.md
# Synchronous Burst Address Generator

This block produces the array address for a synchronous burst memory port. On a rising clock edge it can capture an external address. A capture is started by one of two start strobes: a processor-side strobe or a controller-side strobe. After a capture, the block walks through the other addresses of the aligned four-word group that holds the captured address. It moves one beat on each cycle where the advance input is high. The upper address bits never change during a burst.

Two chip-enable inputs qualify the strobes. The first is active low and the second is active high. A static order input selects how the two low bits move. Low selects linear order, which adds the beat count modulo 4 to the start value. High selects interleaved order, which XORs the start value with the beat count. A new address can be captured on any cycle, so bursting is optional and back-to-back single accesses need no gap.

All control inputs are plain level signals sampled on the rising edge. No stream handshake is involved. The outputs change one cycle after the edge that caused the change: the current address, a selected flag and a flag that tells which strobe began the current access.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is low and after it is released, with no command yet, `sel_o` is 0, `cur_addr` is 0 and `from_proc` is 0.
- R2: When `proc_start`=1, `ce_n`=0 and `ce_hi`=1 at an edge, the next cycle shows `cur_addr` equal to the sampled `ext_addr`, `sel_o`=1 and `from_proc`=1.
- R3: When `ctrl_start`=1, `ce_n`=0 and `ce_hi`=1 at an edge, and the processor strobe is not in effect, the next cycle shows `cur_addr` equal to the sampled `ext_addr`, `sel_o`=1 and `from_proc`=0.
- R4: `proc_start` has no effect at an edge where `ce_n`=1. The controller strobe and the advance input then act as if `proc_start` were 0.
- R5: When the processor strobe is in effect (`proc_start`=1 and `ce_n`=0), `ctrl_start` and `adv` are ignored at that edge.
- R6: A strobe in effect while the chip is not fully enabled deselects the block. The cases are the processor strobe with `ce_hi`=0, or the controller strobe with `ce_n`=1 or `ce_hi`=0. The next cycle shows `sel_o`=0, while `cur_addr` and `from_proc` are held.
- R7: With `order_ilv`=0, each edge with `adv`=1, no strobe in effect and `sel_o`=1 advances the beat count n by one. The low two address bits become (start + n) mod 4, and the upper bits stay equal to the captured upper bits.
- R8: With `order_ilv`=1, the low two bits after n advances are start XOR n, and the upper bits stay unchanged.
- R9: An edge with no strobe in effect and either `adv`=0 or `sel_o`=0 leaves `cur_addr`, `sel_o` and `from_proc` unchanged.
- R10: After four advances the beat count wraps, and the address returns to the captured start address in both orders.
- R11: A capture is accepted on every consecutive cycle, with no idle cycle between captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_addr | input | ADDR_W | External address captured on a start |
| proc_start | input | 1 | Processor-side start strobe, active high, highest priority |
| ctrl_start | input | 1 | Controller-side start strobe, active high |
| adv | input | 1 | Advance the burst by one beat |
| ce_n | input | 1 | Active-low chip enable, also qualifies `proc_start` |
| ce_hi | input | 1 | Active-high chip enable |
| order_ilv | input | 1 | 0 selects linear order, 1 selects interleaved order; static |
| cur_addr | output | ADDR_W | Current array address |
| sel_o | output | 1 | Block is selected and `cur_addr` is valid |
| from_proc | output | 1 | 1 if the current access was begun by `proc_start` |

## Verification
The checker assumes that `order_ilv` does not change between resets. A change would remap the low bits with no clock edge, which would break every hold and step property. The stimulus therefore sets the order only while reset is asserted. It then replays each start value, every pattern of the five control inputs and runs of back-to-back captures in both orders. Expected addresses come from the start value and beat count with plain arithmetic.

// File: rtl/burst_ag_pkg.sv
package burst_ag_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_DESEL = 2'd2,
    CMD_STEP  = 2'd3
  } burst_cmd_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_ag_pkg::*;
(
  input  logic       proc_start,
  input  logic       ctrl_start,
  input  logic       adv,
  input  logic       ce_n,
  input  logic       ce_hi,
  input  logic       active,
  output burst_cmd_e cmd,
  output logic       src_proc
);

  logic proc_live;
  logic chip_on;

  assign proc_live = proc_start & ~ce_n;
  assign chip_on   = ~ce_n & ce_hi;

  // Priority: qualified processor strobe, then controller strobe, then advance
  always_comb begin
    cmd      = CMD_HOLD;
    src_proc = 1'b0;
    if (proc_live) begin
      src_proc = 1'b1;
      cmd      = ce_hi ? CMD_LOAD : CMD_DESEL;
    end else if (ctrl_start) begin
      cmd = chip_on ? CMD_LOAD : CMD_DESEL;
    end else if (adv && active) begin
      cmd = CMD_STEP;
    end
  end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_ag_pkg::*;
#(
  parameter int BEAT_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  burst_cmd_e           cmd,
  output logic [BEAT_BITS-1:0] beat
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat <= '0;
    end else begin
      unique case (cmd)
        CMD_LOAD: beat <= '0;
        CMD_STEP: beat <= beat + 1'b1;
        default:  beat <= beat;
      endcase
    end
  end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int BEAT_BITS = 2
) (
  input  logic [BEAT_BITS-1:0] start_low,
  input  logic [BEAT_BITS-1:0] beat,
  input  logic                 order_ilv,
  output logic [BEAT_BITS-1:0] low_out
);

  logic [BEAT_BITS-1:0] lin_low;
  logic [BEAT_BITS-1:0] ilv_low;

  assign lin_low = start_low + beat;

  for (genvar b = 0; b < BEAT_BITS; b++) begin : g_xor
    assign ilv_low[b] = start_low[b] ^ beat[b];
  end

  assign low_out = order_ilv ? ilv_low : lin_low;

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_ag_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int BEAT_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              proc_start,
  input  logic              ctrl_start,
  input  logic              adv,
  input  logic              ce_n,
  input  logic              ce_hi,
  input  logic              order_ilv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              sel_o,
  output logic              from_proc
);

  localparam int HI_W = ADDR_W - BEAT_BITS;

  burst_cmd_e           cmd;
  logic                 src_proc;
  logic [ADDR_W-1:0]    base_q;
  logic [BEAT_BITS-1:0] beat;
  logic [BEAT_BITS-1:0] low_mapped;

  burst_cmd_decode u_dec (
    .proc_start (proc_start),
    .ctrl_start (ctrl_start),
    .adv        (adv),
    .ce_n       (ce_n),
    .ce_hi      (ce_hi),
    .active     (sel_o),
    .cmd        (cmd),
    .src_proc   (src_proc)
  );

  burst_beat_counter #(.BEAT_BITS(BEAT_BITS)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   (cmd),
    .beat  (beat)
  );

  burst_order_map #(.BEAT_BITS(BEAT_BITS)) u_map (
    .start_low (base_q[BEAT_BITS-1:0]),
    .beat      (beat),
    .order_ilv (order_ilv),
    .low_out   (low_mapped)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      sel_o     <= 1'b0;
      from_proc <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_LOAD: begin
          base_q    <= ext_addr;
          sel_o     <= 1'b1;
          from_proc <= src_proc;
        end
        CMD_DESEL: sel_o <= 1'b0;
        default: ;
      endcase
    end
  end

  assign cur_addr = {base_q[ADDR_W-1 -: HI_W], low_mapped};

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W    = 18,
  parameter int BEAT_BITS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              proc_start,
  input logic              ctrl_start,
  input logic              adv,
  input logic              ce_n,
  input logic              ce_hi,
  input logic              order_ilv,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              sel_o,
  input logic              from_proc
);

  localparam int LW = BEAT_BITS;

  logic p_live, c_live, on, no_strobe;
  assign p_live    = proc_start && !ce_n;
  assign c_live    = !p_live && ctrl_start;
  assign on        = !ce_n && ce_hi;
  assign no_strobe = !p_live && !ctrl_start;

  AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (p_live && ce_hi) |=> (sel_o && from_proc && cur_addr == $past(ext_addr))); // R2

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_live && on) |=> (sel_o && !from_proc && cur_addr == $past(ext_addr))); // R3

  AST_PROC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_start && ce_n && !ctrl_start && !adv) |=> ($stable(cur_addr) && $stable(sel_o))); // R4

  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ((p_live && !ce_hi) || (c_live && !on)) |=> (!sel_o && $stable(cur_addr) && $stable(from_proc))); // R6

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && adv && sel_o && !order_ilv) |=>
      ((cur_addr[LW-1:0] - $past(cur_addr[LW-1:0])) == LW'(1) &&
       cur_addr[ADDR_W-1:LW] == $past(cur_addr[ADDR_W-1:LW]))); // R7

  AST_ILV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && adv && sel_o && order_ilv) |=>
      (cur_addr[LW-1:0] != $past(cur_addr[LW-1:0]) &&
       cur_addr[ADDR_W-1:LW] == $past(cur_addr[ADDR_W-1:LW]))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && (!adv || !sel_o)) |=>
      ($stable(cur_addr) && $stable(sel_o) && $stable(from_proc))); // R9

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_BITS(BEAT_BITS)) u_chk (.*);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

  localparam int AW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          proc_start = 0, ctrl_start = 0, adv = 0, ce_n = 1, ce_hi = 0, order_ilv = 0;
  logic [AW-1:0] cur_addr;
  logic          sel_o, from_proc;

  int n_run = 0;
  int n_fail = 0;

  // independent model state
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  logic          m_sel = 0, m_src = 0;

  always #5 clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .proc_start(proc_start),
    .ctrl_start(ctrl_start), .adv(adv), .ce_n(ce_n), .ce_hi(ce_hi),
    .order_ilv(order_ilv), .cur_addr(cur_addr), .sel_o(sel_o), .from_proc(from_proc)
  );

  function automatic logic [AW-1:0] exp_addr();
    int lo;
    int s;
    s  = int'(m_base[1:0]);
    lo = order_ilv ? (s ^ (m_beat % 4)) : ((s + m_beat) % 4);
    return {m_base[AW-1:2], 2'(lo)};
  endfunction

  task automatic check(string tag);
    logic [AW-1:0] ea;
    ea = exp_addr();
    n_run++;
    if (cur_addr !== ea || sel_o !== m_sel || from_proc !== m_src) begin
      n_fail++;
      $display("FAIL %s: addr=%h sel=%0b src=%0b expected addr=%h sel=%0b src=%0b",
               tag, cur_addr, sel_o, from_proc, ea, m_sel, m_src);
    end
  endtask

  // drive at negedge, clock, update model, check at next negedge
  task automatic cyc(logic p, logic c, logic a, logic cen, logic ceh,
                     logic [AW-1:0] ad, string tag);
    proc_start = p; ctrl_start = c; adv = a; ce_n = cen; ce_hi = ceh; ext_addr = ad;
    @(posedge clk);
    if (p && !cen) begin
      if (ceh) begin m_base = ad; m_beat = 0; m_sel = 1; m_src = 1; end
      else m_sel = 0;
    end else if (c) begin
      if (!cen && ceh) begin m_base = ad; m_beat = 0; m_sel = 1; m_src = 0; end
      else m_sel = 0;
    end else if (a && m_sel) begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk);
    rst_n = 0; order_ilv = mode;
    proc_start = 0; ctrl_start = 0; adv = 0; ce_n = 1; ce_hi = 0;
    repeat (2) @(negedge clk);
    m_base = '0; m_beat = 0; m_sel = 0; m_src = 0;
    check("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    for (int mode = 0; mode < 2; mode++) begin
      do_reset(1'(mode));
      // start-value sweep with full burst and wrap
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] a0;
        a0 = {16'(16'h5A3 + s * 16'h111), 2'(s)};
        cyc(1, 0, 0, 0, 1, a0, "R2 proc load");
        for (int k = 1; k <= 4; k++) begin
          cyc(0, 0, 1, 1, 0, '0, mode ? "R8 interleaved step" : "R7 linear step");
          cyc(0, 0, 0, 0, 1, '0, "R9 idle hold");
        end
        n_run++;
        if (cur_addr !== a0) begin
          n_fail++;
          $display("FAIL R10: addr=%h expected=%h", cur_addr, a0);
        end
        cyc(0, 1, 0, 0, 1, a0 ^ 18'h2_4003, "R3 ctrl load");
        cyc(0, 0, 1, 0, 1, '0, mode ? "R8 step after ctrl" : "R7 step after ctrl");
      end
      // all control-input patterns from a mid-burst selected state
      for (int v = 0; v < 32; v++) begin
        logic p, c, a, cen, ceh;
        string tg;
        {p, c, a, cen, ceh} = 5'(v);
        cyc(1, 0, 0, 0, 1, 18'h1_2341 + 18'(v), "R2 setup");
        cyc(0, 0, 1, 0, 0, '0, "R7 setup step");
        if (p && cen)                  tg = "R4 gated proc strobe";
        else if (p && (c || a))        tg = "R5 proc priority";
        else if ((p && !ceh) || (c && !(!cen && ceh))) tg = "R6 deselect";
        else if (p)                    tg = "R2 proc load";
        else if (c)                    tg = "R3 ctrl load";
        else if (a)                    tg = "R7 advance";
        else                           tg = "R9 hold";
        cyc(p, c, a, cen, ceh, 18'h3_0F0C ^ 18'(v * 7), tg);
        // advance while maybe deselected
        cyc(0, 0, 1, 0, 1, '0, "R9 advance when deselected or R7");
      end
      // back-to-back captures every cycle
      for (int i = 0; i < 12; i++)
        cyc(i % 3 != 0, i % 3 == 0, 1, 0, 1, 18'(i * 18'h0_3A5B + 7), "R11 back-to-back");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule